// File: doc/BRIEF.md
# Parallel Camera Byte Capture and Word Packer

This block takes pixel bytes from a parallel camera port (a pixel clock, a line-valid strobe and an 8-bit data bus) and stores them as 32-bit words in a receive FIFO. The camera signals are sampled by the system clock, which must run at least four times faster than the pixel clock. The capture edge of the pixel clock is programmable, and so are the data polarity and the line-valid gating. Every four accepted bytes form one word, packed either lowest-byte-first or highest-byte-first.

The FIFO drives several flags. A data-ready flag shows it holds anything. A watermark request rises at a level chosen by a 3-bit code. A full flag tracks the current state, and a sticky overrun flag records that a word was lost. A frame counter counts packed words and gives a one-cycle end-of-frame pulse when it reaches the programmed receive count. A software clear empties the FIFO, drops any partial word and restarts the frame count. It leaves the overrun flag untouched, and only reset clears that flag.

Top module: `pcap_top`

## Requirements
- R1: With `cfg_rise_edge`=1, a byte is captured on each 0-to-1 transition of `pix_clk`. With `cfg_rise_edge`=0, a byte is captured on each 1-to-0 transition. The opposite transition captures nothing.
- R2: With `cfg_inv_data`=1, every captured byte is the bitwise inverse of `pix_data`. With `cfg_inv_data`=0, it is `pix_data` unchanged.
- R3: With `cfg_gated`=1, a capture edge is accepted only while `pix_hsync` is at its active level. With `cfg_gated`=0, every capture edge is accepted whatever `pix_hsync` does.
- R4: `cfg_hsync_high`=1 makes a high `pix_hsync` the active level. `cfg_hsync_high`=0 makes a low `pix_hsync` the active level.
- R5: Take four accepted bytes b0,b1,b2,b3 in arrival order. With `cfg_msb_first`=0 they form the word {b3,b2,b1,b0}, so bytes 0x11,0x22,0x33,0x44 give 0x44332211. With `cfg_msb_first`=1 they form {b0,b1,b2,b3}, which gives 0x11223344. Words leave the FIFO in arrival order. `rd_data` shows the oldest word, and `rd_en` removes it.
- R6: `data_ready` is 1 exactly when the FIFO holds at least one word.
- R7: `wm_req` is 1 when the FIFO holds at least N words, where N is chosen by `cfg_wm_code`: 0→4, 1→8, 2→16, 3→24, 4→32, 5→48, 6→64, 7→96.
- R8: `fifo_full` is 1 exactly when the FIFO holds DEPTH (128) words. A word that arrives while the FIFO is full is dropped and sets `overrun`. `overrun` then stays 1 until reset.
- R9: `frame_end` pulses for one cycle when the count of packed words since the last clear or last pulse reaches `cfg_rx_count`, and the count then restarts. A count of 0 never pulses.
- R10: `sw_clear` empties the FIFO, discards any partially packed word and restarts the frame count. It does not change `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_clk | input | 1 | Camera pixel clock, oversampled |
| pix_hsync | input | 1 | Camera line-valid strobe |
| pix_data | input | 8 | Camera data bus |
| cfg_rise_edge | input | 1 | 1: capture on rising edge, 0: falling |
| cfg_inv_data | input | 1 | Invert data bus |
| cfg_gated | input | 1 | Accept bytes only during active line strobe |
| cfg_hsync_high | input | 1 | Line strobe active level (1 high, 0 low) |
| cfg_msb_first | input | 1 | Packing order (0 lowest byte first) |
| cfg_wm_code | input | 3 | Watermark level code |
| cfg_rx_count | input | 22 | Words per frame, 0 disables |
| sw_clear | input | 1 | Empty FIFO and restart packing |
| rd_en | input | 1 | Pop the oldest word |
| rd_data | output | 32 | Oldest word in the FIFO |
| data_ready | output | 1 | FIFO not empty |
| wm_req | output | 1 | Occupancy at or above watermark |
| fifo_full | output | 1 | FIFO full |
| overrun | output | 1 | Sticky word-lost flag |
| frame_end | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench changes the data bus between the two halves of each pixel-clock period. This means a design that captures on the wrong edge stores the inverted filler byte instead of the real one. Bytes sent while the line strobe is inactive are placed among valid ones, both polarities are covered, and the ungated mode is checked as well. A design that ignores gating, or gets the polarity backwards, therefore packs a shifted word. A clear is issued in the middle of a word, so a design that keeps a stale byte index misaligns every word after it. The FIFO is filled across the watermark boundary and past full. A design that does not drop the extra word, loses the sticky flag on a read or clear, or is off by one in the watermark compare is detected by the per-cycle comparison against the reference model.

// File: rtl/pcap_pkg.sv
// Shared types and the watermark decode for the pixel capture packer.
package pcap_pkg;

    typedef enum logic {
        PACK_LOW_FIRST  = 1'b0,
        PACK_HIGH_FIRST = 1'b1
    } pack_order_e;

    // Turns the 3-bit watermark code into a word count.
    function automatic int unsigned wm_words(input logic [2:0] code);
        case (code)
            3'd0:    return 4;
            3'd1:    return 8;
            3'd2:    return 16;
            3'd3:    return 24;
            3'd4:    return 32;
            3'd5:    return 48;
            3'd6:    return 64;
            default: return 96;
        endcase
    endfunction

endpackage

// File: rtl/pcap_front.sv
// Camera-side front end. It registers the pixel clock, line strobe and data
// with the system clock and applies data inversion at that register. It then
// detects the selected pixel-clock edge and qualifies it with line gating.
// Assumes the system clock is at least 4x the pixel clock and that data is
// stable around the capture edge.
module pcap_front #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_clk,
    input  logic              pix_hsync,
    input  logic [BYTE_W-1:0] pix_data,
    input  logic              cfg_rise_edge,
    input  logic              cfg_inv_data,
    input  logic              cfg_gated,
    input  logic              cfg_hsync_high,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_out
);
    logic              clk_q, clk_qq, hs_q;
    logic [BYTE_W-1:0] data_q;
    logic              rise, fall, edge_hit, line_ok;

    // Sample camera inputs and keep one cycle of pixel-clock history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q  <= 1'b0;
            clk_qq <= 1'b0;
            hs_q   <= 1'b0;
            data_q <= '0;
        end else begin
            clk_q  <= pix_clk;
            clk_qq <= clk_q;
            hs_q   <= pix_hsync;
            data_q <= cfg_inv_data ? ~pix_data : pix_data;
        end
    end

    // Edge select and line-valid qualification.
    always_comb begin
        rise     = clk_q & ~clk_qq;
        fall     = ~clk_q & clk_qq;
        edge_hit = cfg_rise_edge ? rise : fall;
        line_ok  = ~cfg_gated | (hs_q == cfg_hsync_high);
        byte_vld = edge_hit & line_ok;
        byte_out = data_q;
    end

endmodule

// File: rtl/pcap_packer.sv
// Gathers LANES accepted bytes into one word in the chosen lane order and
// gives a one-cycle word strobe. A clear drops any partial word.
module pcap_packer
    import pcap_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     cfg_msb_first,
    input  logic                     byte_vld,
    input  logic [BYTE_W-1:0]        byte_in,
    output logic                     word_vld,
    output logic [BYTE_W*LANES-1:0]  word
);
    localparam int WORD_W = BYTE_W * LANES;
    localparam int IW     = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [IW-1:0] LAST = IW'(LANES - 1);

    logic [BYTE_W-1:0] hold [LANES];
    logic [BYTE_W-1:0] nxt  [LANES];
    logic [IW-1:0]     idx;
    logic [WORD_W-1:0] w_low, w_high;
    pack_order_e       order;

    assign order = pack_order_e'(cfg_msb_first);

    // Place each lane into both candidate word layouts.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign nxt[g] = (idx == IW'(g)) ? byte_in : hold[g];
        assign w_low [g*BYTE_W +: BYTE_W]           = nxt[g];
        assign w_high[(LANES-1-g)*BYTE_W +: BYTE_W] = nxt[g];
    end

    // Byte index, lane storage and word strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            word_vld <= 1'b0;
            word     <= '0;
            for (int i = 0; i < LANES; i++) hold[i] <= '0;
        end else if (clear) begin
            idx      <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (byte_vld) begin
                hold[idx] <= byte_in;
                if (idx == LAST) begin
                    idx      <= '0;
                    word_vld <= 1'b1;
                    word     <= (order == PACK_HIGH_FIRST) ? w_high : w_low;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pcap_fifo.sv
// Receive FIFO with the oldest word shown at the output. Writes while full
// are dropped and set a sticky overrun flag that only reset clears.
// Assumes DEPTH is a power of two.
module pcap_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 128
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       wr,
    input  logic [WIDTH-1:0]           wdata,
    input  logic                       rd,
    output logic [WIDTH-1:0]           rdata,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full,
    output logic                       overrun
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    count;
    logic             do_wr, do_rd;

    // Qualified write and read strobes.
    always_comb begin
        full  = (count == CW'(DEPTH));
        do_wr = wr & ~full & ~clear;
        do_rd = rd & (count != '0) & ~clear;
    end

    // Storage array write port.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wdata;
    end

    // Pointers, occupancy and the sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (wr & full & ~clear) overrun <= 1'b1;
            if (clear) begin
                wptr  <= '0;
                rptr  <= '0;
                count <= '0;
            end else begin
                if (do_wr) wptr <= wptr + 1'b1;
                if (do_rd) rptr <= rptr + 1'b1;
                count <= count + CW'(do_wr) - CW'(do_rd);
            end
        end
    end

    assign rdata = mem[rptr];
    assign level = count;

endmodule

// File: rtl/pcap_frame_cnt.sv
// Counts packed words and pulses end-of-frame when the programmed count is
// reached, then restarts. A target of zero disables the pulse.
module pcap_frame_cnt #(
    parameter int CNT_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             word_vld,
    input  logic [CNT_W-1:0] target,
    output logic             frame_end
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = cnt + CNT_W'(1);

    // Word counting and end-of-frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt       <= '0;
            frame_end <= 1'b0;
        end else begin
            frame_end <= 1'b0;
            if (word_vld) begin
                if (target != '0 && cnt_inc == target) begin
                    cnt       <= '0;
                    frame_end <= 1'b1;
                end else begin
                    cnt <= cnt_inc;
                end
            end
        end
    end

endmodule

// File: rtl/pcap_top.sv
// Parallel camera capture packer top. It chains the front end, the packer,
// the receive FIFO and the frame counter, and decodes the watermark.
// Assumes DEPTH is a power of two no smaller than the largest watermark (96).
module pcap_top
    import pcap_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    parameter int DEPTH  = 128,
    parameter int CNT_W  = 22
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pix_clk,
    input  logic                    pix_hsync,
    input  logic [BYTE_W-1:0]       pix_data,
    input  logic                    cfg_rise_edge,
    input  logic                    cfg_inv_data,
    input  logic                    cfg_gated,
    input  logic                    cfg_hsync_high,
    input  logic                    cfg_msb_first,
    input  logic [2:0]              cfg_wm_code,
    input  logic [CNT_W-1:0]        cfg_rx_count,
    input  logic                    sw_clear,
    input  logic                    rd_en,
    output logic [BYTE_W*LANES-1:0] rd_data,
    output logic                    data_ready,
    output logic                    wm_req,
    output logic                    fifo_full,
    output logic                    overrun,
    output logic                    frame_end
);
    localparam int WORD_W = BYTE_W * LANES;
    localparam int CW     = $clog2(DEPTH + 1);

    logic              byte_vld;
    logic [BYTE_W-1:0] byte_val;
    logic              word_vld;
    logic [WORD_W-1:0] word;
    logic [CW-1:0]     level;
    logic [CW-1:0]     wm_lvl;

    pcap_front #(.BYTE_W(BYTE_W)) u_front (
        .clk            (clk),
        .rst_n          (rst_n),
        .pix_clk        (pix_clk),
        .pix_hsync      (pix_hsync),
        .pix_data       (pix_data),
        .cfg_rise_edge  (cfg_rise_edge),
        .cfg_inv_data   (cfg_inv_data),
        .cfg_gated      (cfg_gated),
        .cfg_hsync_high (cfg_hsync_high),
        .byte_vld       (byte_vld),
        .byte_out       (byte_val)
    );

    pcap_packer #(.BYTE_W(BYTE_W), .LANES(LANES)) u_pack (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear         (sw_clear),
        .cfg_msb_first (cfg_msb_first),
        .byte_vld      (byte_vld),
        .byte_in       (byte_val),
        .word_vld      (word_vld),
        .word          (word)
    );

    pcap_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (sw_clear),
        .wr      (word_vld),
        .wdata   (word),
        .rd      (rd_en),
        .rdata   (rd_data),
        .level   (level),
        .full    (fifo_full),
        .overrun (overrun)
    );

    pcap_frame_cnt #(.CNT_W(CNT_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (sw_clear),
        .word_vld  (word_vld),
        .target    (cfg_rx_count),
        .frame_end (frame_end)
    );

    // Watermark compare against the decoded level.
    always_comb begin
        wm_lvl     = CW'(wm_words(cfg_wm_code));
        wm_req     = (level >= wm_lvl);
        data_ready = (level != '0);
    end

endmodule

// File: rtl/pcap_checker.sv
// Protocol checker for the capture packer, bound onto every pcap_top.
module pcap_checker #(
    parameter int CNT_W = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_clear,
    input logic [CNT_W-1:0] cfg_rx_count,
    input logic             data_ready,
    input logic             wm_req,
    input logic             fifo_full,
    input logic             overrun,
    input logic             frame_end
);
    AST_FULL_IMPLIES_READY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> data_ready); // R6
    AST_FULL_ABOVE_WM: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> wm_req); // R7
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R8
    AST_OVERRUN_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(fifo_full)); // R8
    AST_EOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end); // R9
    AST_EOF_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_end) |-> ($past(cfg_rx_count) != '0)); // R9
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clear |=> !data_ready); // R10
endmodule

bind pcap_top pcap_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_clear     (sw_clear),
    .cfg_rx_count (cfg_rx_count),
    .data_ready   (data_ready),
    .wm_req       (wm_req),
    .fifo_full    (fifo_full),
    .overrun      (overrun),
    .frame_end    (frame_end)
);

// File: tb/sim_pcap_top.sv
`timescale 1ns/1ps
module sim_pcap_top;
    localparam int DEPTH = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_clk = 1'b0, pix_hsync = 1'b0;
    logic [7:0]  pix_data = '0;
    logic        cfg_rise_edge = 1'b1, cfg_inv_data = 1'b0, cfg_gated = 1'b0;
    logic        cfg_hsync_high = 1'b1, cfg_msb_first = 1'b0;
    logic [2:0]  cfg_wm_code = 3'd0;
    logic [21:0] cfg_rx_count = '0;
    logic        sw_clear = 1'b0, rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        data_ready, wm_req, fifo_full, overrun, frame_end;

    int checks = 0, errors = 0, cycles = 0, eof_seen = 0;

    always #2.5 clk = ~clk;

    pcap_top u0 (.*);

    function automatic int lvl_of(input logic [2:0] c);
        int t [8] = '{4, 8, 16, 24, 32, 48, 64, 96};
        return t[c];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, stepped on every clock.
    logic        m_c1 = 0, m_c2 = 0, m_h1 = 0;
    logic [7:0]  m_d1 = 0;
    logic [7:0]  m_lane [4];
    int          m_idx = 0, m_cnt = 0;
    bit          m_wpend = 0, m_ovr = 0, m_eof = 0, m_started = 0;
    logic [31:0] m_word = 0;
    logic [31:0] mq [$];

    always @(posedge clk) begin
        m_started = 1;
        if (!rst_n) begin
            m_c1 = 0; m_c2 = 0; m_h1 = 0; m_d1 = 0; m_idx = 0; m_cnt = 0;
            m_wpend = 0; m_ovr = 0; m_eof = 0; mq.delete();
        end else begin
            int  sz;
            bit  ev;
            m_eof = 0;
            if (sw_clear) begin
                mq.delete(); m_cnt = 0;
            end else begin
                sz = mq.size();
                if (rd_en && sz > 0) void'(mq.pop_front());
                if (m_wpend) begin
                    if (sz == DEPTH) m_ovr = 1; else mq.push_back(m_word);
                    if (cfg_rx_count != 0 && m_cnt + 1 == int'(cfg_rx_count)) begin
                        m_cnt = 0; m_eof = 1;
                    end else m_cnt = (m_cnt + 1) % (1 << 22);
                end
            end
            ev = (cfg_rise_edge ? (m_c1 && !m_c2) : (!m_c1 && m_c2)) &&
                 (!cfg_gated || (m_h1 == cfg_hsync_high));
            m_wpend = 0;
            if (sw_clear) m_idx = 0;
            else if (ev) begin
                m_lane[m_idx] = m_d1;
                if (m_idx == 3) begin
                    m_wpend = 1; m_idx = 0;
                    m_word = cfg_msb_first ? {m_lane[0], m_lane[1], m_lane[2], m_lane[3]}
                                           : {m_lane[3], m_lane[2], m_lane[1], m_lane[0]};
                end else m_idx++;
            end
            m_c2 = m_c1; m_c1 = pix_clk; m_h1 = pix_hsync;
            m_d1 = cfg_inv_data ? ~pix_data : pix_data;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (m_started) begin
            chk(data_ready == (mq.size() > 0), "R6 data_ready", 32'(data_ready), 32'(mq.size() > 0));
            chk(fifo_full == (mq.size() == DEPTH), "R8 fifo_full", 32'(fifo_full), 32'(mq.size() == DEPTH));
            chk(wm_req == (mq.size() >= lvl_of(cfg_wm_code)), "R7 wm_req", 32'(wm_req), 32'(mq.size() >= lvl_of(cfg_wm_code)));
            chk(overrun == m_ovr, "R8 overrun", 32'(overrun), 32'(m_ovr));
            chk(frame_end == m_eof, "R9 frame_end", 32'(frame_end), 32'(m_eof));
            if (mq.size() > 0) chk(rd_data == mq[0], "R5 rd_data", rd_data, mq[0]);
            if (frame_end === 1'b1) eof_seen++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic hs = 1'b1);
        pix_data = b; pix_hsync = hs;
        wait_n(2); pix_clk = ~pix_clk;
        wait_n(2); pix_data = ~b;
        wait_n(2); pix_clk = ~pix_clk;
        wait_n(2);
    endtask

    task automatic send4(input logic [31:0] bytes_in_order);
        for (int i = 3; i >= 0; i--) send(bytes_in_order[i*8 +: 8]);
        wait_n(4);
    endtask

    task automatic pop(output logic [31:0] w);
        w = rd_data; rd_en = 1'b1; wait_n(1); rd_en = 1'b0;
    endtask

    task automatic clear_now();
        sw_clear = 1'b1; wait_n(1); sw_clear = 1'b0; wait_n(1);
    endtask

    initial begin
        logic [31:0] w;
        wait_n(4); rst_n = 1'b1; wait_n(1);
        chk(data_ready == 0, "R6 reset ready", 32'(data_ready), 0);
        chk(overrun == 0, "R8 reset overrun", 32'(overrun), 0);
        chk(fifo_full == 0 && wm_req == 0 && frame_end == 0, "R7 reset flags", 32'({fifo_full, wm_req, frame_end}), 0);

        send4(32'h11223344);
        chk(data_ready == 1, "R6 word present", 32'(data_ready), 1);
        pop(w); chk(w == 32'h44332211, "R5 low first", w, 32'h44332211);
        cfg_msb_first = 1; send4(32'h11223344);
        pop(w); chk(w == 32'h11223344, "R5 high first", w, 32'h11223344);
        cfg_msb_first = 0;

        cfg_inv_data = 1; send4(32'h0FF0A500);
        pop(w); chk(w == 32'hFF5A0FF0, "R2 inverted", w, 32'hFF5A0FF0);
        cfg_inv_data = 0;

        cfg_rise_edge = 0; pix_clk = 1; wait_n(4); clear_now();
        send4(32'h01020304);
        pop(w); chk(w == 32'h04030201, "R1 falling edge", w, 32'h04030201);
        pix_clk = 0; wait_n(4); clear_now();
        send4(32'h01020304);
        pop(w); chk(w == 32'hFBFCFDFE, "R1 rising ignored", w, 32'hFBFCFDFE);
        cfg_rise_edge = 1; wait_n(4); clear_now();

        cfg_gated = 1; cfg_hsync_high = 1;
        send(8'hA1, 1); send(8'hB2, 0); send(8'hC3, 1); send(8'hD4, 1); send(8'hE5, 1); wait_n(4);
        pop(w); chk(w == 32'hE5D4C3A1, "R3 gated high", w, 32'hE5D4C3A1);
        cfg_hsync_high = 0;
        send(8'h10, 0); send(8'h99, 1); send(8'h20, 0); send(8'h30, 0); send(8'h40, 0); wait_n(4);
        pop(w); chk(w == 32'h40302010, "R4 gated low", w, 32'h40302010);
        cfg_gated = 0; cfg_hsync_high = 1;
        send(8'h5A, 0); send(8'h6B, 1); send(8'h7C, 0); send(8'h8D, 1); wait_n(4);
        pop(w); chk(w == 32'h8D7C6B5A, "R3 ungated", w, 32'h8D7C6B5A);

        clear_now(); cfg_rx_count = 3; eof_seen = 0;
        send4(32'h01010101); send4(32'h02020202);
        chk(eof_seen == 0, "R9 before count", eof_seen, 0);
        send4(32'h03030303);
        chk(eof_seen == 1, "R9 at count", eof_seen, 1);
        cfg_rx_count = 0;
        send4(32'h04040404); send4(32'h05050505); send4(32'h06060606);
        chk(eof_seen == 1, "R9 zero count", eof_seen, 1);

        clear_now();
        send(8'h77); send(8'h66); wait_n(4); clear_now();
        chk(data_ready == 0, "R10 cleared", 32'(data_ready), 0);
        send4(32'h01020304);
        pop(w); chk(w == 32'h04030201, "R10 index restart", w, 32'h04030201);

        cfg_wm_code = 3'd6;
        for (int k = 0; k < 63; k++) send4({8'(k), 8'(k+1), 8'(k+2), 8'(k+3)});
        chk(wm_req == 0, "R7 below 64", 32'(wm_req), 0);
        send4(32'hCAFE0001);
        chk(wm_req == 1, "R7 at 64", 32'(wm_req), 1);
        for (int c = 0; c < 8; c++) begin
            cfg_wm_code = 3'(c); #1;
            chk(wm_req == (64 >= lvl_of(3'(c))), "R7 code sweep", 32'(wm_req), 32'(64 >= lvl_of(3'(c))));
        end
        wait_n(1);
        for (int k = 0; k < 64; k++) send4({8'(k), 8'hA5, 8'(~k), 8'h3C});
        chk(fifo_full == 1, "R8 full", 32'(fifo_full), 1);
        chk(overrun == 0, "R8 no overrun yet", 32'(overrun), 0);
        send4(32'hDEADBEEF);
        chk(overrun == 1, "R8 overrun set", 32'(overrun), 1);
        pop(w); wait_n(1);
        chk(fifo_full == 0, "R8 full drops", 32'(fifo_full), 0);
        chk(overrun == 1, "R8 sticky after read", 32'(overrun), 1);
        clear_now();
        chk(data_ready == 0, "R10 emptied", 32'(data_ready), 0);
        chk(overrun == 1, "R10 overrun kept", 32'(overrun), 1);

        wait_n(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule